// File: doc/BRIEF.md
# Chainable Periodic Interrupt Timer

This block holds two down-counting timer channels behind a small word-addressed register port. Each channel has a reload value, a readback of its current count, a control word and a sticky expiry flag. An enabled channel decrements once per clock. When the count is already zero, the next count event reloads it from the reload value and sets the flag. The flag, ANDed with the channel's interrupt enable, drives that channel's interrupt request.

Channel 1 can be cascaded onto channel 0. In that mode it steps only in the cycles where channel 0 expires, so the pair acts as one wider counter. A freeze bit at module level, combined with an external debug-halt input, stops every counter. Writes take effect at the clock edge where the write strobe is sampled. Reads are combinational on the address.

Top module: `chainTimer`

## Requirements
- R1: After reset, every register reads 0 and both interrupt requests are low. This covers the reload values, the control words, the flags and the freeze bit.
- R2: The register map uses byte addresses. The freeze control is at 0x000, bit 0. Channel n has its reload value at 0x100+16n, its count readback at 0x104+16n (read-only), its control word at 0x108+16n and its flag at 0x10C+16n, bit 0. Control bit 0 is enable, bit 1 is interrupt enable and bit 2 is chain. Control bits 31..3 ignore writes and read 0.
- R3: A control write that takes enable from 0 to 1 loads the counter from the reload value at that same edge.
- R4: An enabled, unchained and unfrozen channel decrements by 1 each clock. From 0 it reloads and sets its flag on the next clock, so a reload value L gives one flag event every L+1 cycles.
- R5: A reload value written while the channel runs leaves the current count alone and is used at the next reload.
- R6: Writing 1 to flag bit 0 clears the flag, and writing 0 has no effect. If the flag is set and cleared in the same cycle, the set wins.
- R7: The interrupt request is high exactly when the flag and the interrupt enable are both 1. Enabling interrupts while the flag is already set raises the request right after that write.
- R8: With chain set, channel 1 changes only in cycles where channel 0 expires. In those cycles it decrements, or reloads if it is at 0.
- R9: The chain bit of channel 0 has no effect on its counting.
- R10: While the freeze bit is 1 and the debug-halt input is high, no counter changes. Either condition alone does not stop counting.
- R11: A disabled channel neither counts nor sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 12 | Byte address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| dbgHalt | input | 1 | Debug halt; stops the counters when the freeze bit is set |
| irq | output | 2 | One interrupt request per channel |

## Verification
A write changes register state, counters and flags at the edge that samples it. The interrupt output and any readback therefore show the new value in the half cycle after that edge, with no further delay. A count event is due at every edge while the channel runs. The bench's behavioural model advances at each rising edge. Interrupt lines and read data are compared at each falling edge, so every result is checked in the first half-cycle where it is due. The directed sequences count whole clock edges between a write and a readback: reload visible at once, one decrement per edge, a chained step four edges after a reload of 3.

// File: rtl/chainTimerPkg.sv
package chainTimerPkg;
  parameter int unsigned NUM_CH    = 2;
  parameter int unsigned CNT_W     = 32;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned ADDR_W    = 12;
  parameter int unsigned CH_STRIDE = 16;

  localparam logic [ADDR_W-1:0] FRZ_ADDR = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] CH_BASE  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] LOAD_OFS = ADDR_W'('h0);
  localparam logic [ADDR_W-1:0] VAL_OFS  = ADDR_W'('h4);
  localparam logic [ADDR_W-1:0] CTL_OFS  = ADDR_W'('h8);
  localparam logic [ADDR_W-1:0] FLG_OFS  = ADDR_W'('hC);

  // Strobes and levels from the register side to the counting side
  typedef struct packed {
    logic [NUM_CH-1:0] run;
    logic [NUM_CH-1:0] intEn;
    logic [NUM_CH-1:0] chain;
    logic [NUM_CH-1:0] start;
    logic [NUM_CH-1:0] clrFlag;
    logic              frozen;
  } tmrCtl_t;

  function automatic logic [ADDR_W-1:0] regAddr(input int unsigned ch,
                                                 input logic [ADDR_W-1:0] ofs);
    return CH_BASE + ADDR_W'(ch * CH_STRIDE) + ofs;
  endfunction
endpackage

// File: rtl/chainTimerRegs.sv
module chainTimerRegs
  import chainTimerPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          dbgHalt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  input  logic [NUM_CH-1:0]             flagVal,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_CH-1:0][CNT_W-1:0]  loadVal,
  output tmrCtl_t                       ctl
);
  logic                         freezeBit;
  logic [NUM_CH-1:0]            enR, ieR, chR;
  logic [NUM_CH-1:0][CNT_W-1:0] loadR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freezeBit <= 1'b0;
      enR       <= '0;
      ieR       <= '0;
      chR       <= '0;
      loadR     <= '0;
    end else if (wrEn) begin
      if (addr == FRZ_ADDR) freezeBit <= wrData[0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == regAddr(i, LOAD_OFS)) loadR[i] <= CNT_W'(wrData);
        if (addr == regAddr(i, CTL_OFS)) begin
          enR[i] <= wrData[0];
          ieR[i] <= wrData[1];
          chR[i] <= wrData[2];
        end
      end
    end
  end

  always_comb begin
    ctl.run    = enR;
    ctl.intEn  = ieR;
    ctl.chain  = chR;
    ctl.frozen = freezeBit & dbgHalt;
    for (int i = 0; i < NUM_CH; i++) begin
      ctl.start[i]   = wrEn && (addr == regAddr(i, CTL_OFS)) && wrData[0] && !enR[i];
      ctl.clrFlag[i] = wrEn && (addr == regAddr(i, FLG_OFS)) && wrData[0];
    end
  end

  assign loadVal = loadR;

  always_comb begin
    rdData = '0;
    if (addr == FRZ_ADDR) rdData[0] = freezeBit;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == regAddr(i, LOAD_OFS)) rdData = DATA_W'(loadR[i]);
      if (addr == regAddr(i, VAL_OFS))  rdData = DATA_W'(cntVal[i]);
      if (addr == regAddr(i, CTL_OFS))  rdData[2:0] = {chR[i], ieR[i], enR[i]};
      if (addr == regAddr(i, FLG_OFS))  rdData[0] = flagVal[i];
    end
  end
endmodule

// File: rtl/chainTimerCore.sv
module chainTimerCore
  import chainTimerPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  tmrCtl_t                       ctl,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  loadVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  output logic [NUM_CH-1:0]             flagVal,
  output logic [NUM_CH-1:0]             irq
);
  logic [NUM_CH-1:0][CNT_W-1:0] cntR;
  logic [NUM_CH-1:0]            flagR;
  logic [NUM_CH-1:0]            tick, expire;

  // Count events ripple upward: channel 0 never chains
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      tick[i] = ctl.run[i] && !ctl.frozen;
      if (i > 0 && ctl.chain[i]) tick[i] = tick[i] && expire[i-1];
      expire[i] = tick[i] && (cntR[i] == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntR  <= '0;
      flagR <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ctl.start[i])     cntR[i] <= loadVal[i];
        else if (expire[i])   cntR[i] <= loadVal[i];
        else if (tick[i])     cntR[i] <= cntR[i] - 1'b1;
        if (expire[i])        flagR[i] <= 1'b1;
        else if (ctl.clrFlag[i]) flagR[i] <= 1'b0;
      end
    end
  end

  assign cntVal  = cntR;
  assign flagVal = flagR;
  assign irq     = flagR & ctl.intEn;
endmodule

// File: rtl/chainTimer.sv
module chainTimer
  import chainTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              dbgHalt,
  output logic [NUM_CH-1:0] irq
);
  tmrCtl_t                      ctl;
  logic [NUM_CH-1:0][CNT_W-1:0] loadVal;
  logic [NUM_CH-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CH-1:0]            flagVal;

  chainTimerRegs i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .dbgHalt(dbgHalt), .cntVal(cntVal), .flagVal(flagVal),
    .rdData(rdData), .loadVal(loadVal), .ctl(ctl)
  );

  chainTimerCore i_core (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadVal(loadVal),
    .cntVal(cntVal), .flagVal(flagVal), .irq(irq)
  );
endmodule

// File: rtl/chainTimerChecker.sv
module chainTimerChecker
  import chainTimerPkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input tmrCtl_t                       ctl,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  input logic [NUM_CH-1:0]             flagVal,
  input logic [NUM_CH-1:0]             irq
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    localparam bit CAN_CHAIN = (g > 0);

    // R4: free-running channel steps down by one
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rstN)
      ctl.run[g] && !ctl.frozen && !(CAN_CHAIN && ctl.chain[g]) && !ctl.start[g]
        && cntVal[g] != '0
      |=> cntVal[g] == $past(cntVal[g]) - 1'b1);

    // R4: reaching zero raises the flag on the next event
    a_r4_flag_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
      ctl.run[g] && !ctl.frozen && !(CAN_CHAIN && ctl.chain[g]) && cntVal[g] == '0
      |=> flagVal[g]);

    // R6: clear works when no expiry can collide
    a_r6_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
      ctl.clrFlag[g] && (cntVal[g] != '0 || !ctl.run[g] || ctl.frozen)
      |=> !flagVal[g]);

    // R7: request follows flag and enable
    a_r7_irq_high: assert property (@(posedge clk) disable iff (!rstN)
      flagVal[g] && ctl.intEn[g] |-> irq[g]);
    a_r7_irq_low: assert property (@(posedge clk) disable iff (!rstN)
      !flagVal[g] |-> !irq[g]);

    // R10: frozen counters hold
    a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rstN)
      ctl.frozen && !ctl.start[g] |=> $stable(cntVal[g]));

    // R11: disabled channel is idle
    a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.run[g] && !ctl.start[g] |=> $stable(cntVal[g]) && !$rose(flagVal[g]));

    if (g > 0) begin : gChain
      // R8: chained channel waits for the lower channel's expiry
      a_r8_chain_wait: assert property (@(posedge clk) disable iff (!rstN)
        ctl.run[g] && ctl.chain[g] && !ctl.start[g]
          && !(ctl.run[g-1] && !ctl.frozen && cntVal[g-1] == '0)
        |=> $stable(cntVal[g]));
    end
  end

  // R9: chain bit on channel 0 does not slow it
  a_r9_no_chain_ch0: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run[0] && ctl.chain[0] && !ctl.frozen && !ctl.start[0] && cntVal[0] != '0
    |=> cntVal[0] == $past(cntVal[0]) - 1'b1);
endmodule

bind chainTimer chainTimerChecker i_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .cntVal(cntVal), .flagVal(flagVal), .irq(irq)
);

// File: tb/test_chainTimer.sv
module test_chainTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        dbgHalt = 1'b0;
  logic [1:0]  irq;

  int nChk = 0;
  int nErr = 0;
  int cyc  = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chainTimer i_chainTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dbgHalt(dbgHalt), .irq(irq)
  );

  function automatic logic [11:0] aLoad(int c); return 12'(256 + 16*c);      endfunction
  function automatic logic [11:0] aVal(int c);  return 12'(256 + 16*c + 4);  endfunction
  function automatic logic [11:0] aCtl(int c);  return 12'(256 + 16*c + 8);  endfunction
  function automatic logic [11:0] aFlg(int c);  return 12'(256 + 16*c + 12); endfunction

  // Behavioural reference state
  bit [31:0] mLoad[2], mCnt[2];
  bit        mEn[2], mIe[2], mCh[2], mFlag[2];
  bit        mFrz;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mCnt[k]) begin
        mLoad[k] = 0; mCnt[k] = 0; mEn[k] = 0; mIe[k] = 0; mCh[k] = 0; mFlag[k] = 0;
      end
      mFrz = 0;
    end else begin
      bit halt, step0, step1, hit0, hit1;
      halt  = mFrz && dbgHalt;
      step0 = mEn[0] && !halt;
      hit0  = step0 && mCnt[0] == 0;
      step1 = mEn[1] && !halt && (!mCh[1] || hit0);
      hit1  = step1 && mCnt[1] == 0;
      if (step0) mCnt[0] = hit0 ? mLoad[0] : mCnt[0] - 1;
      if (step1) mCnt[1] = hit1 ? mLoad[1] : mCnt[1] - 1;
      if (wrEn) begin
        if (addr == 12'h000) mFrz = wrData[0];
        for (int k = 0; k < 2; k++) begin
          if (addr == aFlg(k) && wrData[0]) mFlag[k] = 0;
          if (addr == aCtl(k)) begin
            if (wrData[0] && !mEn[k]) mCnt[k] = mLoad[k];
            mEn[k] = wrData[0]; mIe[k] = wrData[1]; mCh[k] = wrData[2];
          end
        end
        for (int k = 0; k < 2; k++)
          if (addr == aLoad(k)) mLoad[k] = wrData;
      end
      if (hit0) mFlag[0] = 1;
      if (hit1) mFlag[1] = 1;
    end
  end

  function automatic bit [31:0] mRead(logic [11:0] a);
    bit [31:0] r = 0;
    if (a == 12'h000) r[0] = mFrz;
    for (int k = 0; k < 2; k++) begin
      if (a == aLoad(k)) r = mLoad[k];
      if (a == aVal(k))  r = mCnt[k];
      if (a == aCtl(k))  r[2:0] = {mCh[k], mIe[k], mEn[k]};
      if (a == aFlg(k))  r[0] = mFlag[k];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk("R7 irq vs model", {30'b0, irq}, {30'b0, mIe[1] && mFlag[1], mIe[0] && mFlag[0]});
      chk("R2 readback vs model", rdData, mRead(addr));
    end
    if (cyc > 20000) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      finishRun();
    end
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(); addr = a; wrData = d; wrEn = 1'b1;
    step(); wrEn = 1'b0;
  endtask
  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    rd(aCtl(0), v);   chk("R1 ctl0", v, 0);
    rd(aFlg(1), v);   chk("R1 flag1", v, 0);
    rd(12'h000, v);   chk("R1 freeze", v, 0);
    rd(aLoad(1), v);  chk("R1 load1", v, 0);
    chk("R1 irq", {30'b0, irq}, 0);
    // R2 reserved control bits
    wr(aCtl(1), 32'hFFFF_FFF8);
    rd(aCtl(1), v);   chk("R2 reserved bits", v, 0);
    // R3 start loads counter, R4 decrement
    wr(aLoad(0), 10);
    wr(aCtl(0), 1);
    rd(aVal(0), v);   chk("R3 load on enable", v, 10);
    repeat (3) step();
    rd(aVal(0), v);   chk("R4 three decrements", v, 7);
    // R5 new reload applies at next reload
    wr(aLoad(0), 3);
    for (int n = 0; n < 40; n++) begin
      rd(aVal(0), v);
      if (v == 0) break;
      step();
    end
    chk("R5 reached zero", v, 0);
    step();
    rd(aVal(0), v);   chk("R5 new reload used", v, 3);
    // R10 freeze with debug halt
    wr(12'h000, 1);
    dbgHalt = 1'b1;
    rd(aVal(0), v);
    repeat (5) step();
    rd(aVal(0), v2);  chk("R10 frozen hold", v2, v);
    // R6 write 0 does nothing, R7 enable irq with flag set
    wr(aFlg(0), 0);
    rd(aFlg(0), v);   chk("R6 write zero keeps flag", v, 1);
    wr(aCtl(0), 3);
    chk("R7 irq on enable", {31'b0, irq[0]}, 1);
    rd(aVal(0), v);   chk("R3 no restart when already on", v, v2);
    wr(aFlg(0), 1);
    rd(aFlg(0), v);   chk("R6 write one clears", v, 0);
    chk("R7 irq drops", {31'b0, irq[0]}, 0);
    dbgHalt = 1'b0;
    // R9 chain bit on channel 0 ignored
    wr(aCtl(0), 7);
    rd(aVal(0), v);
    step();
    rd(aVal(0), v2);  chk("R9 ch0 keeps counting", v2, (v == 0) ? 32'd3 : v - 1);
    // R8 chained channel 1
    wr(aCtl(0), 0);
    wr(aLoad(1), 2);
    wr(aCtl(1), 5);
    rd(aVal(1), v);   chk("R8 chained load", v, 2);
    repeat (5) step();
    rd(aVal(1), v);   chk("R8 holds without lower expiry", v, 2);
    wr(aCtl(0), 1);
    repeat (4) step();
    rd(aVal(1), v);   chk("R8 steps on lower expiry", v, 1);
    repeat (30) step();
    // R11 disabled channel stays idle
    wr(aCtl(1), 0);
    wr(aFlg(1), 1);
    repeat (20) step();
    rd(aFlg(1), v);   chk("R11 disabled no flag", v, 0);
    chk("R11 no irq1", {31'b0, irq[1]}, 0);
    // R10 debug halt alone does not freeze
    wr(12'h000, 0);
    dbgHalt = 1'b1;
    rd(aVal(0), v);
    step();
    rd(aVal(0), v2);  chk("R10 halt alone runs", v2, (v == 0) ? 32'd3 : v - 1);
    dbgHalt = 1'b0;
    repeat (10) step();
    finishRun();
  end
endmodule